// File: doc/BRIEF.md
# Key-Derivation Command and Done Consistency Monitor

This block sits beside the link between a key-derivation controller and the hash or MAC engine it drives. It observes the controller's three operation strobes (advance, identity, generate), the signal that marks the final data beat sent to the engine, the engine's done response, and the configuration input that selects the disable operation. The block never alters the traffic it watches. When it sees an illegal or inconsistent pattern, it sets a fault status bit and raises a fatal alert. Both stay set until reset.

An operation starts on the first cycle that exactly one strobe is high while the monitor is idle. That strobe is captured and must stay the only strobe asserted until the engine's done is accepted. The done window opens on the cycle after the final data beat and closes on the cycle in which done is accepted. A done seen outside that window is a fault. Reset is synchronous and active high, and both outputs are registered, so a fault seen in cycle N appears on the outputs after the clock edge that ends cycle N.

Top module: `kdi_monitor`

## Requirements
- R1: While reset is high, and after it, `fault_status` is 3'b000 and `fatal_alert` is 0 until a fault is seen.
- R2: Two or more of {adv_en, id_en, gen_en} high in one cycle sets `fault_status[0]` (command fault) on the next clock edge.
- R3: During an operation, a change from the captured strobe to a different single strobe before done is accepted sets `fault_status[0]`.
- R4: During an operation, all strobes going low before done is accepted sets `fault_status[0]`.
- R5: A complete operation raises no fault: the strobe is held, `last_sent` is pulsed, and `eng_done` arrives in a later cycle. After it, a new operation with a different strobe is legal.
- R6: `eng_done` while no window is open sets `fault_status[1]` (done fault). This covers done while idle and done in the same cycle as `last_sent`.
- R7: A second `eng_done` after the one that closed the window sets `fault_status[1]`.
- R8: With `op_disable` high, an asserted `adv_en` or `gen_en` sets `fault_status[2]` (control consistency fault). `id_en` alone under `op_disable` is no fault.
- R9: `fatal_alert` rises in the same cycle as the first fault status bit and equals the OR of the status bits.
- R10: Status bits and the alert are sticky. Later legal operations do not clear them. Only reset does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| adv_en | input | 1 | Advance operation strobe |
| id_en | input | 1 | Identity operation strobe |
| gen_en | input | 1 | Generate operation strobe |
| op_disable | input | 1 | Configured operation is disable |
| last_sent | input | 1 | Final data beat sent to the engine this cycle |
| eng_done | input | 1 | Engine done response |
| fault_status | output | 3 | bit0 command fault, bit1 done fault, bit2 control consistency fault |
| fatal_alert | output | 1 | Sticky fatal alert |

## Verification
The bench targets done in the same cycle as the final data beat. A monitor that opened the window one cycle early would accept that done without a fault. The bench also drops every strobe in the middle of an operation, which a check that only compares one onehot value with another would miss. It sends a second done right after a legal one, which catches a window that never closes. It asserts identity under disable, which a design that flags every strobe would wrongly report. Last, it runs a clean operation after a fault to show that status is not cleared by later legal traffic.

// File: rtl/kdi_pkg.sv
package kdi_pkg;
  localparam int CMD_W    = 3;
  localparam int CMD_ADV  = 0;
  localparam int CMD_ID   = 1;
  localparam int CMD_GEN  = 2;
  localparam int FAULT_W  = 3;
  localparam int FLT_CMD  = 0;
  localparam int FLT_DONE = 1;
  localparam int FLT_CTRL = 2;
endpackage

// File: rtl/kdi_cmd_tracker.sv
module kdi_cmd_tracker #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] strobe,
  input  logic         done_ok,
  output logic         op_active,
  output logic         cmd_err
);
  localparam int CW = $clog2(W + 1);

  logic         busy_q;
  logic [W-1:0] cmd_q;
  logic [CW-1:0] hot_cnt;
  logic         multi, single, start, mismatch;

  always_comb begin
    hot_cnt  = CW'($countones(strobe));
    multi    = hot_cnt > CW'(1);
    single   = hot_cnt == CW'(1);
    start    = !busy_q && single;
    mismatch = busy_q && !multi && (strobe != cmd_q);
    cmd_err  = multi || mismatch;
    op_active = busy_q || start;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cmd_q  <= '0;
    end else if (busy_q && done_ok) begin
      busy_q <= 1'b0;
      cmd_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cmd_q  <= strobe;
    end
  end

  // R3: captured command is locked until done is accepted
  p_cmd_locked_r3: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !done_ok) |=> (busy_q && cmd_q == $past(cmd_q)));

  // R2: a captured command is always a single strobe
  p_cmd_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> $onehot(cmd_q));
endmodule

// File: rtl/kdi_done_window.sv
module kdi_done_window (
  input  logic clk,
  input  logic rst,
  input  logic op_active,
  input  logic last_sent,
  input  logic eng_done,
  output logic done_ok,
  output logic done_err
);
  logic win_q;

  always_comb begin
    done_ok  = eng_done && win_q;
    done_err = eng_done && !win_q;
  end

  always_ff @(posedge clk) begin
    if (rst)                        win_q <= 1'b0;
    else if (win_q && eng_done)     win_q <= 1'b0;
    else if (last_sent && op_active) win_q <= 1'b1;
  end

  // R7: an accepted done closes the window
  p_win_closes_r7: assert property (@(posedge clk) disable iff (rst)
    (win_q && eng_done) |=> !win_q);

  // R6: the window only opens after a final beat
  p_win_opens_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(win_q) |-> $past(last_sent));
endmodule

// File: rtl/kdi_fault_sticky.sv
module kdi_fault_sticky #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt,
  output logic [W-1:0] status,
  output logic         alert
);
  logic [W-1:0] flag_q;
  logic         alert_q;

  for (genvar i = 0; i < W; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) flag_q[i] <= 1'b0;
      else     flag_q[i] <= flag_q[i] | evt[i];
    end

    // R10: each status bit holds once set
    p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
      flag_q[i] |=> flag_q[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) alert_q <= 1'b0;
    else     alert_q <= alert_q | (|evt);
  end

  assign status = flag_q;
  assign alert  = alert_q;

  // R9: alert mirrors the OR of status bits
  p_alert_tracks_r9: assert property (@(posedge clk) disable iff (rst)
    alert_q == (|flag_q));
endmodule

// File: rtl/kdi_monitor.sv
module kdi_monitor
  import kdi_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               adv_en,
  input  logic               id_en,
  input  logic               gen_en,
  input  logic               op_disable,
  input  logic               last_sent,
  input  logic               eng_done,
  output logic [FAULT_W-1:0] fault_status,
  output logic               fatal_alert
);
  logic [CMD_W-1:0]   strobe;
  logic [FAULT_W-1:0] evt;
  logic op_active, cmd_err, done_ok, done_err;

  always_comb begin
    strobe          = '0;
    strobe[CMD_ADV] = adv_en;
    strobe[CMD_ID]  = id_en;
    strobe[CMD_GEN] = gen_en;
  end

  kdi_cmd_tracker #(.W(CMD_W)) u_cmd (
    .clk(clk), .rst(rst), .strobe(strobe), .done_ok(done_ok),
    .op_active(op_active), .cmd_err(cmd_err)
  );

  kdi_done_window u_win (
    .clk(clk), .rst(rst), .op_active(op_active), .last_sent(last_sent),
    .eng_done(eng_done), .done_ok(done_ok), .done_err(done_err)
  );

  always_comb begin
    evt           = '0;
    evt[FLT_CMD]  = cmd_err;
    evt[FLT_DONE] = done_err;
    evt[FLT_CTRL] = op_disable && (adv_en || gen_en);
  end

  kdi_fault_sticky #(.W(FAULT_W)) u_flt (
    .clk(clk), .rst(rst), .evt(evt),
    .status(fault_status), .alert(fatal_alert)
  );

  // R2: more than one strobe flags a command fault
  p_multi_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    ($countones({adv_en, id_en, gen_en}) > 1) |=> fault_status[FLT_CMD]);

  // R8: advance or generate under disable flags a control fault
  p_disable_strobe_r8: assert property (@(posedge clk) disable iff (rst)
    (op_disable && (adv_en || gen_en)) |=> fault_status[FLT_CTRL]);

  // R6: done with no prior final beat flags a done fault
  p_stray_done_r6: assert property (@(posedge clk) disable iff (rst)
    (eng_done && !$past(last_sent) && !$past(op_active)) |=> fault_status[FLT_DONE]);
endmodule

// File: tb/kdi_monitor_bench.sv
module kdi_monitor_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic adv_en = 0, id_en = 0, gen_en = 0, op_disable = 0, last_sent = 0, eng_done = 0;
  logic [2:0] fault_status;
  logic fatal_alert;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  kdi_monitor u_kdi_monitor (
    .clk(clk), .rst(rst), .adv_en(adv_en), .id_en(id_en), .gen_en(gen_en),
    .op_disable(op_disable), .last_sent(last_sent), .eng_done(eng_done),
    .fault_status(fault_status), .fatal_alert(fatal_alert)
  );

  task automatic step(input logic [2:0] s, input logic dis, input logic last, input logic done);
    @(negedge clk);
    {gen_en, id_en, adv_en} = s;
    op_disable = dis; last_sent = last; eng_done = done;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input logic [2:0] exp_st, input string tag);
    logic exp_al;
    exp_al = |exp_st;
    total++;
    if (fault_status !== exp_st || fatal_alert !== exp_al) begin
      bad++;
      $display("FAIL %s: status=%b alert=%b expected status=%b alert=%b",
               tag, fault_status, fatal_alert, exp_st, exp_al);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    {gen_en, id_en, adv_en} = 3'b000;
    op_disable = 0; last_sent = 0; eng_done = 0;
    @(posedge clk); @(posedge clk); #1;
    check(3'b000, "R1 during reset");
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_legal();
    do_reset();
    step(3'b001, 0, 0, 0);
    step(3'b001, 0, 0, 0);
    step(3'b001, 0, 1, 0);
    step(3'b001, 0, 0, 0);
    step(3'b001, 0, 0, 1);
    check(3'b000, "R5 legal advance op");
    step(3'b000, 0, 0, 0);
    step(3'b100, 0, 0, 0);
    step(3'b100, 0, 1, 0);
    step(3'b100, 0, 0, 1);
    step(3'b000, 0, 0, 0);
    check(3'b000, "R5 following generate op");
  endtask

  task automatic t_multi();
    do_reset();
    step(3'b000, 0, 0, 0);
    check(3'b000, "R1 idle after reset");
    step(3'b101, 0, 0, 0);
    check(3'b001, "R2 R9 two strobes");
    do_reset();
    step(3'b111, 0, 0, 0);
    check(3'b001, "R2 three strobes");
  endtask

  task automatic t_switch();
    do_reset();
    step(3'b001, 0, 0, 0);
    check(3'b000, "R3 start ok");
    step(3'b010, 0, 0, 0);
    check(3'b001, "R3 strobe switch");
  endtask

  task automatic t_drop();
    do_reset();
    step(3'b010, 0, 0, 0);
    step(3'b010, 0, 1, 0);
    step(3'b000, 0, 0, 0);
    check(3'b001, "R4 strobes dropped");
  endtask

  task automatic t_done_idle();
    do_reset();
    step(3'b000, 0, 0, 1);
    check(3'b010, "R6 done while idle");
  endtask

  task automatic t_done_same();
    do_reset();
    step(3'b001, 0, 0, 0);
    step(3'b001, 0, 1, 1);
    check(3'b010, "R6 done with final beat");
  endtask

  task automatic t_done_twice();
    do_reset();
    step(3'b001, 0, 0, 0);
    step(3'b001, 0, 1, 0);
    step(3'b001, 0, 0, 1);
    check(3'b000, "R7 first done legal");
    step(3'b000, 0, 0, 1);
    check(3'b010, "R7 second done");
  endtask

  task automatic t_disable();
    do_reset();
    step(3'b010, 1, 0, 0);
    check(3'b000, "R8 identity under disable");
    step(3'b010, 1, 1, 0);
    step(3'b010, 1, 0, 1);
    check(3'b000, "R8 identity op completes");
    step(3'b000, 1, 0, 0);
    step(3'b100, 1, 0, 0);
    check(3'b100, "R8 generate under disable");
    do_reset();
    step(3'b001, 1, 0, 0);
    check(3'b100, "R8 advance under disable");
  endtask

  task automatic t_sticky();
    do_reset();
    step(3'b011, 0, 0, 0);
    step(3'b000, 0, 0, 0);
    step(3'b001, 0, 0, 0);
    step(3'b001, 0, 1, 0);
    step(3'b001, 0, 0, 1);
    step(3'b000, 0, 0, 0);
    check(3'b001, "R10 fault held after legal op");
    do_reset();
    step(3'b000, 0, 0, 0);
    check(3'b000, "R1 R10 reset clears");
  endtask

  initial begin
    t_legal();
    t_multi();
    t_switch();
    t_drop();
    t_done_idle();
    t_done_same();
    t_done_twice();
    t_disable();
    t_sticky();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: run hung, actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule